// File: doc/BRIEF.md
# CAN Error State Classifier

This block turns a snapshot of a CAN controller's error-flag byte into one controller error state, and keeps statistics on how that state moves. Each time the flag byte is presented with its valid strobe, the block works out the new state by fixed priority. It counts each rise into the warning and passive levels, counts receive-buffer overflows, and raises a one-cycle event with a cause code that says what happened.

A jump across several levels at once counts at every level it passes. When the controller goes bus-off and automatic recovery is not enabled by parameter, the block latches a halt output. It then ignores further flag snapshots until a restart request arrives. The restart returns the state to error-active. Counting of bus errors on the wire is left to the controller itself.

Top module: `can_err_classifier`

## Requirements
- R1: The flag byte uses bit5 = bus-off, bit4 = transmit passive, bit3 = receive passive, bit2 = transmit warning, bit1 = receive warning, bit6 = receive buffer 0 overflow, bit7 = receive buffer 1 overflow, and bit0 = combined warning. Bit0 plays no part in the state. The state is picked in the priority bus-off, transmit passive, receive passive, transmit warning, receive warning, and falls back to error-active when none of these is set. The encoding is 0 active, 1 warning, 2 passive, 3 bus-off.
- R2: The state output takes its new value on the clock edge that samples an accepted strobe. While the strobe is low, the state holds.
- R3: The cause output uses bit0 for transmit warning, bit1 for receive warning, bit2 for transmit passive, bit3 for receive passive, bit4 for bus-off, bit5 for overflow and bit6 for a return to active. One of the state bits 0 to 4 is set only when the state changes, and it names the flag that chose the new state. The cause is all zero in any cycle without an event.
- R4: The warning counter rises by one on each accepted strobe that moves the state from active to warning, passive or bus-off.
- R5: The passive counter rises by one on each accepted strobe that moves the state from active or warning to passive or bus-off. A move from active straight to passive or bus-off therefore raises both the warning and passive counters. A move to a lower level raises neither.
- R6: Each overflow bit that is set in an accepted strobe adds one to the overflow counter and one to the receive-error counter, so both bits set adds two to each. Cause bit5 is set whenever either overflow bit is set.
- R7: Every counter saturates at its all-ones value (65535 with the default 16-bit width) and never wraps.
- R8: The event output is high for exactly the one cycle after an accepted strobe that changes the state or carries an overflow bit, and it is low at all other times.
- R9: With automatic recovery disabled, entering bus-off sets the halt output. While halt is high, strobes change no state, counter, event or cause.
- R10: A restart request clears halt and sets the state to active on the next edge. It changes no counter and raises no event. It wins over a strobe in the same cycle, and that strobe is dropped.
- R11: After reset the state is active, halt, event and cause are low, and all counters are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flag_valid | input | 1 | Strobe qualifying flag_byte |
| flag_byte | input | 8 | Error-flag snapshot |
| restart_req | input | 1 | Return to active and clear halt |
| err_state | output | 2 | Current error state |
| halted | output | 1 | Bus-off latched, waiting for restart |
| evt_pulse | output | 1 | One-cycle event |
| evt_cause | output | 7 | Cause bits for the event |
| warn_cnt | output | CNT_W | Entries into warning or above |
| pasv_cnt | output | CNT_W | Entries into passive or above |
| ovf_cnt | output | CNT_W | Receive overflows |
| rxerr_cnt | output | CNT_W | Receive errors from overflows |

## Verification
A wrong held state shows up at the ports at the very next strobe. The cause code, the event and the warning and passive counters all depend on both the old and the new state, so a stale or mis-decoded state gives a wrong cause or a missing or extra count one cycle after that strobe. A halt that sticks or clears wrongly shows on the first strobe that arrives while the block should be ignoring input, or on the first one after a restart, as a state or counter that moves when it should not. Saturation faults surface only after tens of thousands of overflow strobes, so the bench drives a long run of double overflows to reach that point.

// File: rtl/can_err_pkg.sv
package can_err_pkg;

  typedef enum logic [1:0] {
    ST_ACTIVE  = 2'd0,
    ST_WARN    = 2'd1,
    ST_PASSIVE = 2'd2,
    ST_BUSOFF  = 2'd3
  } err_state_e;

  // flag byte bit positions
  localparam int unsigned FB_RX_WARN = 1;
  localparam int unsigned FB_TX_WARN = 2;
  localparam int unsigned FB_RX_PASV = 3;
  localparam int unsigned FB_TX_PASV = 4;
  localparam int unsigned FB_BUSOFF  = 5;
  localparam int unsigned FB_OVF0    = 6;
  localparam int unsigned FB_OVF1    = 7;

  // cause bit positions
  localparam int unsigned CZ_TX_WARN = 0;
  localparam int unsigned CZ_RX_WARN = 1;
  localparam int unsigned CZ_TX_PASV = 2;
  localparam int unsigned CZ_RX_PASV = 3;
  localparam int unsigned CZ_BUSOFF  = 4;
  localparam int unsigned CZ_OVF     = 5;
  localparam int unsigned CZ_RECOVER = 6;
  localparam int unsigned CAUSE_W    = 7;
  localparam int unsigned LVL_CZ_W   = 5;

endpackage

// File: rtl/can_err_prio.sv
module can_err_prio
  import can_err_pkg::*;
(
  input  logic [7:0]          flags,
  output err_state_e          lvl,
  output logic [LVL_CZ_W-1:0] lvl_cause
);

  always_comb begin
    lvl       = ST_ACTIVE;
    lvl_cause = '0;
    if (flags[FB_BUSOFF]) begin
      lvl                  = ST_BUSOFF;
      lvl_cause[CZ_BUSOFF] = 1'b1;
    end else if (flags[FB_TX_PASV]) begin
      lvl                   = ST_PASSIVE;
      lvl_cause[CZ_TX_PASV] = 1'b1;
    end else if (flags[FB_RX_PASV]) begin
      lvl                   = ST_PASSIVE;
      lvl_cause[CZ_RX_PASV] = 1'b1;
    end else if (flags[FB_TX_WARN]) begin
      lvl                   = ST_WARN;
      lvl_cause[CZ_TX_WARN] = 1'b1;
    end else if (flags[FB_RX_WARN]) begin
      lvl                   = ST_WARN;
      lvl_cause[CZ_RX_WARN] = 1'b1;
    end
  end

  always_comb begin
    a_prio_onehot: assert ($onehot0(lvl_cause)); // R1
  end

endmodule

// File: rtl/can_err_satcnt.sv
module can_err_satcnt #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned INC_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [INC_W-1:0] inc,
  output logic [CNT_W-1:0] cnt
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W:0]   sum;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    sum    = {1'b0, cnt} + {{(CNT_W + 1 - INC_W){1'b0}}, inc};
    cnt_en = (inc != '0);
    cnt_d  = sum[CNT_W] ? CNT_MAX : sum[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (cnt_en) cnt <= cnt_d;
  end

  AST_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    cnt >= $past(cnt)); // R7
  AST_CNT_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CNT_MAX) |=> (cnt == CNT_MAX)); // R7

endmodule

// File: rtl/can_err_classifier.sv
module can_err_classifier
  import can_err_pkg::*;
#(
  parameter int unsigned CNT_W        = 16,
  parameter bit          AUTO_RESTART = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flag_valid,
  input  logic [7:0]       flag_byte,
  input  logic             restart_req,
  output logic [1:0]       err_state,
  output logic             halted,
  output logic             evt_pulse,
  output logic [6:0]       evt_cause,
  output logic [CNT_W-1:0] warn_cnt,
  output logic [CNT_W-1:0] pasv_cnt,
  output logic [CNT_W-1:0] ovf_cnt,
  output logic [CNT_W-1:0] rxerr_cnt
);

  localparam int unsigned NCNT  = 4;
  localparam int unsigned INC_W = 2;
  localparam int unsigned IX_WARN = 0;
  localparam int unsigned IX_PASV = 1;
  localparam int unsigned IX_OVF  = 2;
  localparam int unsigned IX_RXE  = 3;

  err_state_e          state_q, state_d;
  logic                halt_q, halt_d;
  logic                evt_q, evt_d;
  logic [CAUSE_W-1:0]  cause_q, cause_d;
  err_state_e          lvl;
  logic [LVL_CZ_W-1:0] lvl_cause;
  logic                accept, changed, ovf_any;
  logic [INC_W-1:0]    ovf_num;
  logic [INC_W-1:0]    cnt_inc [NCNT];
  logic [CNT_W-1:0]    cnt_val [NCNT];

  can_err_prio u_prio (
    .flags     (flag_byte),
    .lvl       (lvl),
    .lvl_cause (lvl_cause)
  );

  always_comb begin
    accept  = flag_valid && !restart_req && !halt_q;
    changed = accept && (lvl != state_q);
    ovf_num = {1'b0, flag_byte[FB_OVF0]} + {1'b0, flag_byte[FB_OVF1]};
    ovf_any = accept && (ovf_num != '0);

    state_d = state_q;
    halt_d  = halt_q;
    if (restart_req) begin
      state_d = ST_ACTIVE;
      halt_d  = 1'b0;
    end else if (accept) begin
      state_d = lvl;
      if (lvl == ST_BUSOFF && !AUTO_RESTART) halt_d = 1'b1;
    end

    evt_d   = changed || ovf_any;
    cause_d = '0;
    if (changed) begin
      cause_d[LVL_CZ_W-1:0] = lvl_cause;
      cause_d[CZ_RECOVER]   = (lvl == ST_ACTIVE);
    end
    cause_d[CZ_OVF] = ovf_any;

    cnt_inc[IX_WARN] = {1'b0, accept && state_q == ST_ACTIVE && lvl != ST_ACTIVE};
    cnt_inc[IX_PASV] = {1'b0, accept && (state_q == ST_ACTIVE || state_q == ST_WARN)
                              && (lvl == ST_PASSIVE || lvl == ST_BUSOFF)};
    cnt_inc[IX_OVF]  = accept ? ovf_num : '0;
    cnt_inc[IX_RXE]  = accept ? ovf_num : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_ACTIVE;
      halt_q  <= 1'b0;
      evt_q   <= 1'b0;
      cause_q <= '0;
    end else begin
      state_q <= state_d;
      halt_q  <= halt_d;
      evt_q   <= evt_d;
      cause_q <= cause_d;
    end
  end

  for (genvar g = 0; g < NCNT; g++) begin : g_cnt
    can_err_satcnt #(.CNT_W(CNT_W), .INC_W(INC_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (cnt_inc[g]),
      .cnt   (cnt_val[g])
    );
  end

  assign err_state = state_q;
  assign halted    = halt_q;
  assign evt_pulse = evt_q;
  assign evt_cause = cause_q;
  assign warn_cnt  = cnt_val[IX_WARN];
  assign pasv_cnt  = cnt_val[IX_PASV];
  assign ovf_cnt   = cnt_val[IX_OVF];
  assign rxerr_cnt = cnt_val[IX_RXE];

  AST_STATE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(flag_valid) && !$past(restart_req)) |-> (state_q == $past(state_q))); // R2
  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_q && !restart_req) |=> (halt_q && state_q == ST_BUSOFF)); // R9
  AST_HALT_FROZEN_CNT: assert property (@(posedge clk) disable iff (!rst_n)
    halt_q |=> ($stable(warn_cnt) && $stable(pasv_cnt) && $stable(ovf_cnt))); // R9
  AST_RESTART_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    restart_req |=> (!halt_q && state_q == ST_ACTIVE && !evt_q)); // R10
  AST_EVT_FROM_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    evt_q |-> $past(flag_valid && !restart_req && !halt_q)); // R8
  AST_QUIET_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_q |-> (cause_q == '0)); // R3
  AST_WARN_BELOW_PASV: assert property (@(posedge clk) disable iff (!rst_n)
    (pasv_cnt != $past(pasv_cnt)) |-> $past(state_q != ST_PASSIVE && state_q != ST_BUSOFF)); // R5

endmodule

// File: tb/tb_can_err_classifier.sv
module tb_can_err_classifier;

  localparam int CNT_W = 16;
  localparam int NV    = 15;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             flag_valid;
  logic [7:0]       flag_byte;
  logic             restart_req;
  logic [1:0]       err_state;
  logic             halted;
  logic             evt_pulse;
  logic [6:0]       evt_cause;
  logic [CNT_W-1:0] warn_cnt, pasv_cnt, ovf_cnt, rxerr_cnt;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  can_err_classifier #(.CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .flag_valid(flag_valid), .flag_byte(flag_byte),
    .restart_req(restart_req), .err_state(err_state), .halted(halted),
    .evt_pulse(evt_pulse), .evt_cause(evt_cause), .warn_cnt(warn_cnt),
    .pasv_cnt(pasv_cnt), .ovf_cnt(ovf_cnt), .rxerr_cnt(rxerr_cnt)
  );

  // flags, state, evt, cause, warn, pasv, ovf (cumulative from reset)
  localparam logic [41:0] VEC [NV] = '{
    {8'h00, 2'd0, 1'b0, 7'h00, 8'd0, 8'd0, 8'd0},
    {8'h02, 2'd1, 1'b1, 7'h02, 8'd1, 8'd0, 8'd0},
    {8'h06, 2'd1, 1'b0, 7'h00, 8'd1, 8'd0, 8'd0},
    {8'h08, 2'd2, 1'b1, 7'h08, 8'd1, 8'd1, 8'd0},
    {8'h00, 2'd0, 1'b1, 7'h40, 8'd1, 8'd1, 8'd0},
    {8'h10, 2'd2, 1'b1, 7'h04, 8'd2, 8'd2, 8'd0},
    {8'h1F, 2'd2, 1'b0, 7'h00, 8'd2, 8'd2, 8'd0},
    {8'h04, 2'd1, 1'b1, 7'h01, 8'd2, 8'd2, 8'd0},
    {8'h40, 2'd0, 1'b1, 7'h60, 8'd2, 8'd2, 8'd1},
    {8'h41, 2'd0, 1'b1, 7'h20, 8'd2, 8'd2, 8'd2},
    {8'hC0, 2'd0, 1'b1, 7'h20, 8'd2, 8'd2, 8'd4},
    {8'h01, 2'd0, 1'b0, 7'h00, 8'd2, 8'd2, 8'd4},
    {8'h0A, 2'd2, 1'b1, 7'h08, 8'd3, 8'd3, 8'd4},
    {8'h80, 2'd0, 1'b1, 7'h60, 8'd3, 8'd3, 8'd5},
    {8'h20, 2'd3, 1'b1, 7'h10, 8'd4, 8'd4, 8'd5}
  };

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic strobe(input logic [7:0] f, input logic rs);
    @(negedge clk);
    flag_valid  = 1'b1;
    flag_byte   = f;
    restart_req = rs;
    @(negedge clk);
    flag_valid  = 1'b0;
    restart_req = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic chk_reset();
    chk("R11", "state", 32'(err_state), 0);
    chk("R11", "halt", 32'(halted), 0);
    chk("R11", "evt", 32'(evt_pulse), 0);
    chk("R11", "cause", 32'(evt_cause), 0);
    chk("R11", "counters", 32'(warn_cnt | pasv_cnt | ovf_cnt | rxerr_cnt), 0);
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    flag_valid = 1'b0; flag_byte = 8'h00; restart_req = 1'b0;
    do_reset();
    chk_reset();

    // table walk: R1 priority and encoding, R3 cause, R4/R5 cascade, R6 overflow, R8 event
    for (int i = 0; i < NV; i++) begin
      strobe(VEC[i][41:34], 1'b0);
      chk("R1", $sformatf("v%0d state", i), 32'(err_state), 32'(VEC[i][33:32]));
      chk("R8", $sformatf("v%0d evt", i), 32'(evt_pulse), 32'(VEC[i][31]));
      chk("R3", $sformatf("v%0d cause", i), 32'(evt_cause), 32'(VEC[i][30:24]));
      chk("R4", $sformatf("v%0d warn", i), 32'(warn_cnt), 32'(VEC[i][23:16]));
      chk("R5", $sformatf("v%0d pasv", i), 32'(pasv_cnt), 32'(VEC[i][15:8]));
      chk("R6", $sformatf("v%0d ovf", i), 32'(ovf_cnt), 32'(VEC[i][7:0]));
      chk("R6", $sformatf("v%0d rxerr", i), 32'(rxerr_cnt), 32'(VEC[i][7:0]));
      chk("R9", $sformatf("v%0d halt", i), 32'(halted), 32'(VEC[i][33:32] == 2'd3));
    end

    // R8 pulse lasts one cycle
    @(negedge clk);
    chk("R8", "evt after one cycle", 32'(evt_pulse), 0);

    // R9 halted: strobes ignored
    strobe(8'hC2, 1'b0);
    chk("R9", "halted state", 32'(err_state), 3);
    chk("R9", "halted ovf", 32'(ovf_cnt), 5);
    chk("R9", "halted evt", 32'(evt_pulse), 0);
    chk("R9", "halt held", 32'(halted), 1);

    // R10 restart wins over same-cycle strobe
    strobe(8'h02, 1'b1);
    chk("R10", "state", 32'(err_state), 0);
    chk("R10", "halt", 32'(halted), 0);
    chk("R10", "evt", 32'(evt_pulse), 0);
    chk("R10", "warn", 32'(warn_cnt), 4);

    // R2 no strobe, state holds
    @(negedge clk);
    flag_byte = 8'h20;
    repeat (3) @(negedge clk);
    chk("R2", "hold without strobe", 32'(err_state), 0);
    chk("R2", "no evt without strobe", 32'(evt_pulse), 0);

    // R2 state follows the strobe edge
    strobe(8'h04, 1'b0);
    chk("R2", "state after strobe", 32'(err_state), 1);

    // R11 mid-run reset
    do_reset();
    chk_reset();

    // R7 saturation with a long run of double overflows
    @(negedge clk);
    flag_valid = 1'b1; flag_byte = 8'hC0;
    repeat (33000) @(negedge clk);
    flag_valid = 1'b0;
    @(negedge clk);
    chk("R7", "ovf saturated", 32'(ovf_cnt), 32'hFFFF);
    chk("R7", "rxerr saturated", 32'(rxerr_cnt), 32'hFFFF);
    strobe(8'h40, 1'b0);
    chk("R7", "ovf stays saturated", 32'(ovf_cnt), 32'hFFFF);
    chk("R6", "cause with saturated ovf", 32'(evt_cause), 32'h20);

    finish_run();
  end

endmodule